// File: doc/BRIEF.md
# Comparator Event and Fault Controller

This block is the digital side of an analog comparator. It takes the comparator's raw output bit, which is asynchronous to the system clock, and passes it through a two-flop synchroniser. It can then invert the bit. An edge detector watches the result for a rising edge, a falling edge or either. When the chosen edge occurs, a sticky event flag is set. A fault output is driven either from that flag or from the live processed level, and it can be forced low.

A small register bus reaches three registers. The mode register holds the fault, inversion, edge, enable and input-select fields. The status register returns the event flag and the live level, and reading it clears the flag. The lock register blocks writes to the mode register. The enable bit and the two input-select codes are driven straight out to the analog front end.

The edge detector is a three-state machine:
- `ST_OFF`: the comparator is disabled.
- `ST_LOW`: the last sampled processed level was 0.
- `ST_HIGH`: the last sampled processed level was 1.

Its transitions are:
- OFF→LOW or OFF→HIGH on enable, following the current level, with no event.
- LOW→HIGH, which is a rise.
- HIGH→LOW, which is a fall.
- any state→OFF on disable.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: After reset, the mode register reads 0, `fault` is 0, `ana_en` is 0 and both select outputs are 0.
- R2: The mode register is at offset 0x04. Its fields are:
  - bit 14: fault enable.
  - bit 13: fault source.
  - bit 12: invert.
  - bits 10:9: edge code.
  - bit 8: comparator enable.
  - bits 6:4: plus-input select.
  - bits 2:0: minus-input select.
  
  All other bits read back as 0. A read returns data on `bus_rdata` in the same cycle that `bus_re` is high, and `bus_rdata` is 0 when `bus_re` is low.
- R3: The lock register is at offset 0x0C, bit 0. It is always writable. While it is 1, writes to the mode register are ignored.
- R4: Edge code 0 flags rising edges only, and edge code 1 flags falling edges only. These edges are of the processed level. A change on `cmp_raw` sets the flag on the third rising clock edge after it.
- R5: Edge codes 2 and 3 both flag either edge.
- R6: The status register is at offset 0x08. Bit 0 is the sticky event flag and bit 1 is the processed level. A read of this register clears the flag at the end of the read cycle.
- R7: An edge event in the same cycle as a status read leaves the flag set.
- R8: When the invert bit is 1, the synchronised comparator bit is inverted before it is reported as the level and before edge detection.
- R9: When the fault source bit is 0, `fault` follows the event flag. When it is 1, `fault` follows the processed level.
- R10: When the fault enable bit is 0, `fault` is 0.
- R11: `ana_en` equals the comparator enable bit. While that bit is 0, no edge sets the flag.
- R12: Enabling the comparator while the level is already 1 does not set the flag.
- R13: `ana_sel_pos` and `ana_sel_neg` carry the two 3-bit select fields unchanged, including codes above 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_re` is high |
| cmp_raw | input | 1 | Asynchronous comparator output |
| ana_en | output | 1 | Comparator enable to the analog side |
| ana_sel_pos | output | 3 | Plus-input select code |
| ana_sel_neg | output | 3 | Minus-input select code |
| fault | output | 1 | Fault output |

## Verification
The comparator input is driven with isolated rising and falling steps under each edge code. This separates rise-only and fall-only detection from the any-edge codes, and it shows that code 3 behaves the same as code 2. The same steps are repeated with inversion set, so a detector that ignores the invert bit reports the wrong edge. Steps made while the comparator is disabled, followed by enabling it with the level already high, separate a correctly idled detector from one that keeps stale history. A rising step timed so that its event lands in the same cycle as a status read checks that the set wins over the clear. A level-source run then shows the fault pin following the input without stickiness.

// File: rtl/cmp_evt_pkg.sv
`timescale 1ns/1ps
package cmp_evt_pkg;

    localparam int MODE_OFS = 8'h04;
    localparam int STAT_OFS = 8'h08;
    localparam int LOCK_OFS = 8'h0C;

    typedef enum logic [1:0] {
        EDGE_RISE    = 2'd0,
        EDGE_FALL    = 2'd1,
        EDGE_ANY     = 2'd2,
        EDGE_ANY_ALT = 2'd3
    } edge_mode_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } det_state_e;

    typedef struct packed {
        logic       flt_en;
        logic       flt_lvl;
        logic       inv;
        edge_mode_e edge_mode;
        logic       cmp_on;
        logic [2:0] sel_pos;
        logic [2:0] sel_neg;
    } mode_t;

    function automatic mode_t word_to_mode(input logic [31:0] w);
        mode_t m;
        m.flt_en    = w[14];
        m.flt_lvl   = w[13];
        m.inv       = w[12];
        m.edge_mode = edge_mode_e'(w[10:9]);
        m.cmp_on    = w[8];
        m.sel_pos   = w[6:4];
        m.sel_neg   = w[2:0];
        return m;
    endfunction

    function automatic logic [31:0] mode_to_word(input mode_t m);
        logic [31:0] w;
        w        = '0;
        w[14]    = m.flt_en;
        w[13]    = m.flt_lvl;
        w[12]    = m.inv;
        w[10:9]  = m.edge_mode;
        w[8]     = m.cmp_on;
        w[6:4]   = m.sel_pos;
        w[2:0]   = m.sel_neg;
        return w;
    endfunction

endpackage

// File: rtl/cmp_evt_sync.sv
`timescale 1ns/1ps
module cmp_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[gi] <= 1'b0;
                    else        chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/cmp_evt_edge.sv
`timescale 1ns/1ps
module cmp_evt_edge
    import cmp_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       lvl,
    input  edge_mode_e edge_mode,
    output logic       evt
);
    det_state_e state, nxt;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:  nxt = en ? (lvl ? ST_HIGH : ST_LOW) : ST_OFF;
            ST_LOW:  nxt = !en ? ST_OFF : (lvl ? ST_HIGH : ST_LOW);
            ST_HIGH: nxt = !en ? ST_OFF : (lvl ? ST_HIGH : ST_LOW);
            default: nxt = ST_OFF;
        endcase
    end

    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state)
            ST_LOW:  rise = en && lvl;
            ST_HIGH: fall = en && !lvl;
            default: ;
        endcase
        unique case (edge_mode)
            EDGE_RISE:    evt = rise;
            EDGE_FALL:    evt = fall;
            EDGE_ANY:     evt = rise || fall;
            EDGE_ANY_ALT: evt = rise || fall;
            default:      evt = 1'b0;
        endcase
    end

    // R11: a disabled detector reports nothing
    a_r11_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !evt);
    // R4: an event needs the level to have moved since the last cycle
    a_r4_evt_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (lvl != $past(lvl)));
endmodule

// File: rtl/cmp_evt_regs.sv
`timescale 1ns/1ps
module cmp_evt_regs
    import cmp_evt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    input  logic [DATA_W-1:0] wdata,
    input  logic              stat_flag,
    input  logic              stat_lvl,
    output mode_t             mode,
    output logic              stat_rd,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(LOCK_OFS);

    logic        locked;
    logic [31:0] wword;
    logic [31:0] rword;

    assign wword = 32'(wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode   <= '0;
            locked <= 1'b0;
        end else if (we) begin
            if (addr == A_MODE && !locked) mode <= word_to_mode(wword);
            if (addr == A_LOCK)            locked <= wword[0];
        end
    end

    assign stat_rd = re && (addr == A_STAT);

    always_comb begin
        rword = '0;
        if (re) begin
            unique case (addr)
                A_MODE:  rword = mode_to_word(mode);
                A_STAT:  rword = {30'b0, stat_lvl, stat_flag};
                A_LOCK:  rword = {31'b0, locked};
                default: rword = '0;
            endcase
        end
    end

    assign rdata = DATA_W'(rword);

    logic unused_wbits;
    assign unused_wbits = ^{wword[31:15], wword[11], wword[7], wword[3]};

    // R3: a locked mode register does not change
    a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(mode));
endmodule

// File: rtl/cmp_evt_ctrl.sv
`timescale 1ns/1ps
module cmp_evt_ctrl
    import cmp_evt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cmp_raw,
    output logic              ana_en,
    output logic [2:0]        ana_sel_pos,
    output logic [2:0]        ana_sel_neg,
    output logic              fault
);
    mode_t mode;
    logic  sync_q, lvl, evt, flag, stat_rd;

    cmp_evt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .re(bus_re),
        .wdata(bus_wdata), .stat_flag(flag), .stat_lvl(lvl), .mode(mode),
        .stat_rd(stat_rd), .rdata(bus_rdata)
    );

    cmp_evt_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(cmp_raw), .dout(sync_q)
    );

    assign lvl = sync_q ^ mode.inv;

    cmp_evt_edge u_edge (
        .clk(clk), .rst_n(rst_n), .en(mode.cmp_on), .lvl(lvl),
        .edge_mode(mode.edge_mode), .evt(evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag <= 1'b0;
        else if (evt)     flag <= 1'b1;
        else if (stat_rd) flag <= 1'b0;
    end

    always_comb begin
        if (!mode.flt_en)      fault = 1'b0;
        else if (mode.flt_lvl) fault = lvl;
        else                   fault = flag;
    end

    assign ana_en      = mode.cmp_on;
    assign ana_sel_pos = mode.sel_pos;
    assign ana_sel_neg = mode.sel_neg;

    // R7: an event always leaves the flag set
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag);
    // R6: a status read with no event clears the flag
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !evt) |=> !flag);
    // R6: the flag is sticky otherwise
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !stat_rd) |=> flag);
    // R10: disabled fault path stays low
    a_r10_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.flt_en |-> !fault);
endmodule

// File: tb/test_cmp_evt_ctrl.sv
`timescale 1ns/1ps
module test_cmp_evt_ctrl;
    localparam int K_RD = 0, K_FLT = 1, K_EN = 2, K_POS = 3, K_NEG = 4;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmp_raw = 1'b0;
    logic        ana_en, fault;
    logic [2:0]  ana_sel_pos, ana_sel_neg;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    item_t sb[$];

    always #5 clk = ~clk;

    cmp_evt_ctrl i_cmp_evt_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_raw(cmp_raw), .ana_en(ana_en), .ana_sel_pos(ana_sel_pos),
        .ana_sel_neg(ana_sel_neg), .fault(fault)
    );

    // monitor: compare queued expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] obs;
                it = sb.pop_front();
                case (it.kind)
                    K_RD:    obs = bus_rdata;
                    K_FLT:   obs = {31'b0, fault};
                    K_EN:    obs = {31'b0, ana_en};
                    K_POS:   obs = {29'b0, ana_sel_pos};
                    default: obs = {29'b0, ana_sel_neg};
                endcase
                n_checks++;
                if (obs !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, obs, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input int kind, input logic [31:0] exp, input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    task automatic expect_now(input int kind, input logic [31:0] exp, input string req);
        push(kind, exp, req);
        tick(1);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick(1);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        bus_addr = a; bus_re = 1'b1;
        push(K_RD, exp, req);
        tick(1);
        bus_re = 1'b0;
    endtask

    task automatic rd_nochk(input logic [7:0] a);
        bus_addr = a; bus_re = 1'b1;
        tick(1);
        bus_re = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd(8'h04, 32'h0, "R1");
        expect_now(K_FLT, 0, "R1");
        expect_now(K_EN, 0, "R1");
        expect_now(K_POS, 0, "R1");
        // R2 / R11 / R13 basic mode write
        wr(8'h04, 32'h0000_0123);
        expect_now(K_EN, 1, "R11");
        expect_now(K_POS, 2, "R13");
        expect_now(K_NEG, 3, "R13");
        rd(8'h04, 32'h0000_0123, "R2");
        // R3 lock
        wr(8'h0C, 32'h1);
        rd(8'h0C, 32'h1, "R3");
        wr(8'h04, 32'h0);
        rd(8'h04, 32'h0000_0123, "R3");
        wr(8'h0C, 32'h0);
        // R4 rising only
        wr(8'h04, 32'h0000_4100);
        tick(4);
        rd(8'h08, 32'h0, "R6");
        cmp_raw = 1'b1; tick(3);
        expect_now(K_FLT, 1, "R4");
        rd(8'h08, 32'h3, "R6");
        expect_now(K_FLT, 0, "R6");
        cmp_raw = 1'b0; tick(4);
        expect_now(K_FLT, 0, "R4");
        // R4 falling only
        wr(8'h04, 32'h0000_4300);
        cmp_raw = 1'b1; tick(4);
        expect_now(K_FLT, 0, "R4");
        cmp_raw = 1'b0; tick(3);
        expect_now(K_FLT, 1, "R4");
        rd(8'h08, 32'h1, "R6");
        // R5 any edge, codes 2 and 3
        wr(8'h04, 32'h0000_4500);
        cmp_raw = 1'b1; tick(3);
        expect_now(K_FLT, 1, "R5");
        rd_nochk(8'h08);
        cmp_raw = 1'b0; tick(3);
        expect_now(K_FLT, 1, "R5");
        rd_nochk(8'h08);
        wr(8'h04, 32'h0000_4700);
        cmp_raw = 1'b1; tick(3);
        expect_now(K_FLT, 1, "R5");
        rd_nochk(8'h08);
        // R8 inversion with rising code
        wr(8'h04, 32'h0000_5100);
        tick(3);
        expect_now(K_FLT, 0, "R8");
        rd(8'h08, 32'h0, "R8");
        cmp_raw = 1'b0; tick(3);
        expect_now(K_FLT, 1, "R8");
        rd(8'h08, 32'h3, "R8");
        // R9 level source
        wr(8'h04, 32'h0000_6100);
        expect_now(K_FLT, 0, "R9");
        cmp_raw = 1'b1; tick(2);
        expect_now(K_FLT, 1, "R9");
        cmp_raw = 1'b0; tick(2);
        expect_now(K_FLT, 0, "R9");
        // R10 fault disabled
        wr(8'h04, 32'h0000_2100);
        cmp_raw = 1'b1; tick(4);
        expect_now(K_FLT, 0, "R10");
        rd(8'h08, 32'h3, "R10");
        // R11 disabled: no edges
        wr(8'h04, 32'h0000_4000);
        expect_now(K_EN, 0, "R11");
        cmp_raw = 1'b0; tick(4);
        cmp_raw = 1'b1; tick(4);
        expect_now(K_FLT, 0, "R11");
        rd(8'h08, 32'h2, "R11");
        // R12 re-enable with level high
        wr(8'h04, 32'h0000_4100);
        tick(4);
        expect_now(K_FLT, 0, "R12");
        // R7 set wins over read clear
        cmp_raw = 1'b0; tick(4);
        cmp_raw = 1'b1; tick(2);
        rd(8'h08, 32'h2, "R7");
        expect_now(K_FLT, 1, "R7");
        // R13 codes above 3, R2 reserved bits
        wr(8'h04, 32'h0000_0157);
        expect_now(K_POS, 5, "R13");
        expect_now(K_NEG, 7, "R13");
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'h0000_7777, "R2");
        bus_addr = 8'h04;
        expect_now(K_RD, 0, "R2");
        tick(2);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(100_000 * 10);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule